// File: doc/BRIEF.md
# Instruction Execution Cycle Sequencer

This block sits beside the fetch path of a byte-oriented processor core. When a new instruction arrives, its opcode and the byte that follows it are presented together with a valid pulse. The block then decides how many memory cycles the instruction occupies. It also works out how many of those cycles fetch an instruction byte. It steps through the instruction one memory-cycle strobe at a time. The program counter may advance only on the strobes that fetch bytes, and it stays where it is on the execution strobes that follow.

The timing comes from a lookup over a fixed set of supported opcodes. One rule adds a cycle: the add-from-direct-address opcode (25h) costs one more cycle when its address byte names one of a parameterised set of special registers. Any opcode outside the supported set is treated as a one-byte, one-cycle instruction. A pulse marks the last memory cycle of each instruction, and the next opcode is taken on the strobe after that one.

Top module: `instr_cycle_seq`

## Requirements
- R1: Every instruction occupies at least 1 and at most 10 memory cycles (strobes), counted from the accepting strobe through the strobe that carries instr_done.
- R2: The one-byte opcodes take these cycle counts: 13h takes 1, D4h takes 2, 22h takes 3, A4h takes 9 and 84h takes 10.
- R3: The two-byte opcodes take these cycle counts: 24h takes 2, 25h takes 2 and 80h takes 3. No two-byte instruction takes fewer than 2 cycles.
- R4: Opcode 25h takes 3 cycles when its second byte equals one of the special register addresses. The default list is D0h, 81h, 86h, A8h, E8h, B8h, B1h, F8h and F1h. No other opcode gains a cycle from its second byte.
- R5: pc_adv is high on the first B strobes of an instruction, where B is its byte count. It is low on every later strobe of that instruction.
- R6: instr_done is high on exactly the final strobe of an instruction. The strobe after it may accept a new opcode.
- R7: busy goes high after the accepting strobe of an instruction with more than one cycle, and it drops after its final strobe. A one-cycle instruction never raises busy.
- R8: A valid pulse that arrives while an instruction is in progress is ignored, and the running instruction's timing is unchanged.
- R9: pc_adv and instr_done are only high together with mem_strobe. Without a strobe, the sequencer's state, including busy, holds.
- R10: After reset, busy, pc_adv and instr_done are low.
- R11: An opcode outside the supported set is taken as one byte and one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_strobe | input | 1 | Marks a cycle in which one memory cycle completes |
| op_valid | input | 1 | A new opcode and second byte are presented |
| opcode | input | 8 | Fetched opcode |
| operand | input | 8 | Second instruction byte (direct address or immediate) |
| pc_adv | output | 1 | Program counter may advance on this strobe |
| busy | output | 1 | An instruction has strobes still to run |
| instr_done | output | 1 | Final memory cycle of the current instruction |

## Verification
The embedded assertions check the properties that hold on every cycle. pc_adv and instr_done never appear without a strobe, and busy holds through strobe-free cycles. busy only falls after a done pulse, and it stays up while a non-final strobe is running. Every accepted shape lies within 1 to 10 cycles, and a two-byte shape never has fewer than two. The exact cycle counts per opcode need the bench's scenarios to show them. So do the special-register extra cycle, the split between advancing and stalled strobes, the ignored mid-instruction pulses and back-to-back acceptance. The bench compares every clock against a behavioural model and counts strobes per instruction.

// File: rtl/icseq_pkg.sv
package icseq_pkg;
  localparam int unsigned MAX_CYCLES = 10;
  localparam int unsigned MAX_BYTES  = 2;
  localparam int unsigned CYC_W  = $clog2(MAX_CYCLES + 1);
  localparam int unsigned BYTE_W = $clog2(MAX_BYTES + 1);

  typedef struct packed {
    logic [CYC_W-1:0]  cycles;
    logic [BYTE_W-1:0] bytes;
  } instr_shape_t;
endpackage

// File: rtl/icseq_sreg_match.sv
module icseq_sreg_match #(
  parameter int unsigned            N_SREG     = 9,
  parameter logic [N_SREG*8-1:0]    SREG_ADDRS = 72'hD0_81_86_A8_E8_B8_B1_F8_F1
) (
  input  logic [7:0] addr,
  output logic       hit
);
  logic [N_SREG-1:0] hit_vec;

  for (genvar g = 0; g < N_SREG; g++) begin : g_cmp
    assign hit_vec[g] = (addr == SREG_ADDRS[g*8 +: 8]);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/icseq_decode.sv
module icseq_decode
  import icseq_pkg::*;
#(
  parameter int unsigned            N_SREG     = 9,
  parameter logic [N_SREG*8-1:0]    SREG_ADDRS = 72'hD0_81_86_A8_E8_B8_B1_F8_F1
) (
  input  logic [7:0]   opcode,
  input  logic [7:0]   operand,
  output instr_shape_t shape
);
  logic sreg_hit;

  icseq_sreg_match #(.N_SREG(N_SREG), .SREG_ADDRS(SREG_ADDRS)) u_match (
    .addr (operand),
    .hit  (sreg_hit)
  );

  always_comb begin
    shape.cycles = CYC_W'(1);
    shape.bytes  = BYTE_W'(1);
    unique case (opcode)
      8'h13: shape.cycles = CYC_W'(1);
      8'hD4: shape.cycles = CYC_W'(2);
      8'h22: shape.cycles = CYC_W'(3);
      8'hA4: shape.cycles = CYC_W'(9);
      8'h84: shape.cycles = CYC_W'(10);
      8'h24: begin shape.cycles = CYC_W'(2); shape.bytes = BYTE_W'(2); end
      8'h25: begin
        shape.cycles = sreg_hit ? CYC_W'(3) : CYC_W'(2);
        shape.bytes  = BYTE_W'(2);
      end
      8'h80: begin shape.cycles = CYC_W'(3); shape.bytes = BYTE_W'(2); end
      default: ;
    endcase
  end
endmodule

// File: rtl/icseq_track.sv
module icseq_track
  import icseq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mem_strobe,
  input  logic         op_valid,
  input  instr_shape_t shape,
  output logic         pc_adv,
  output logic         busy,
  output logic         instr_done
);
  logic              active_q, active_d;
  logic [CYC_W-1:0]  rem_cyc_q, rem_cyc_d;
  logic [BYTE_W-1:0] rem_byte_q, rem_byte_d;
  logic              accept;

  assign accept = mem_strobe && op_valid && !active_q;

  always_comb begin
    pc_adv     = 1'b0;
    instr_done = 1'b0;
    active_d   = active_q;
    rem_cyc_d  = rem_cyc_q;
    rem_byte_d = rem_byte_q;
    if (accept) begin
      pc_adv     = 1'b1;
      instr_done = (shape.cycles == CYC_W'(1));
      active_d   = (shape.cycles > CYC_W'(1));
      rem_cyc_d  = shape.cycles - CYC_W'(1);
      rem_byte_d = shape.bytes - BYTE_W'(1);
    end else if (mem_strobe && active_q) begin
      pc_adv     = (rem_byte_q != '0);
      instr_done = (rem_cyc_q == CYC_W'(1));
      active_d   = (rem_cyc_q > CYC_W'(1));
      rem_cyc_d  = rem_cyc_q - CYC_W'(1);
      rem_byte_d = (rem_byte_q != '0) ? rem_byte_q - BYTE_W'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      rem_cyc_q  <= '0;
      rem_byte_q <= '0;
    end else if (mem_strobe) begin
      active_q   <= active_d;
      rem_cyc_q  <= rem_cyc_d;
      rem_byte_q <= rem_byte_d;
    end
  end

  assign busy = active_q;

  AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> mem_strobe); // R9
  AST_ADV_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |-> mem_strobe); // R9
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_strobe |=> $stable(busy)); // R9
  AST_FELL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(instr_done)); // R6
  AST_SHAPE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (shape.cycles >= CYC_W'(1) && shape.cycles <= CYC_W'(MAX_CYCLES))); // R1
  AST_TWO_BYTE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && shape.bytes == BYTE_W'(2)) |-> shape.cycles >= CYC_W'(2)); // R3
  AST_BUSY_ON_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && shape.cycles > CYC_W'(1)) |=> busy); // R7
  AST_KEEP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_strobe && !instr_done) |=> busy); // R8
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import icseq_pkg::*;
#(
  parameter int unsigned            N_SREG     = 9,
  parameter logic [N_SREG*8-1:0]    SREG_ADDRS = 72'hD0_81_86_A8_E8_B8_B1_F8_F1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_strobe,
  input  logic       op_valid,
  input  logic [7:0] opcode,
  input  logic [7:0] operand,
  output logic       pc_adv,
  output logic       busy,
  output logic       instr_done
);
  logic         rst_meta_q, rst_sync_q;
  instr_shape_t shape;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  icseq_decode #(.N_SREG(N_SREG), .SREG_ADDRS(SREG_ADDRS)) u_decode (
    .opcode  (opcode),
    .operand (operand),
    .shape   (shape)
  );

  icseq_track u_track (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .mem_strobe (mem_strobe),
    .op_valid   (op_valid),
    .shape      (shape),
    .pc_adv     (pc_adv),
    .busy       (busy),
    .instr_done (instr_done)
  );
endmodule

// File: tb/instr_cycle_seq_tb_top.sv
module instr_cycle_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_strobe = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic       pc_adv, busy, instr_done;

  int errors = 0;
  int checks = 0;

  int m_active = 0;
  int m_rem = 0;
  int m_brem = 0;

  always #10 clk = ~clk;

  instr_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mem_strobe(mem_strobe), .op_valid(op_valid),
    .opcode(opcode), .operand(operand),
    .pc_adv(pc_adv), .busy(busy), .instr_done(instr_done)
  );

  function automatic void lookup(input logic [7:0] op, input logic [7:0] opr,
                                 output int n, output int b);
    bit sreg;
    sreg = (opr == 8'hD0) || (opr == 8'h81) || (opr == 8'h86) || (opr == 8'hA8) ||
           (opr == 8'hE8) || (opr == 8'hB8) || (opr == 8'hB1) || (opr == 8'hF8) ||
           (opr == 8'hF1);
    n = 1; b = 1;
    case (op)
      8'h13: n = 1;
      8'hD4: n = 2;
      8'h22: n = 3;
      8'hA4: n = 9;
      8'h84: n = 10;
      8'h24: begin n = 2; b = 2; end
      8'h25: begin n = sreg ? 3 : 2; b = 2; end
      8'h80: begin n = 3; b = 2; end
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, compare just after, update model at posedge
  task automatic cycle(input bit s, input bit v, input logic [7:0] op, input logic [7:0] opr);
    int n, b, e_adv, e_done, e_busy;
    @(negedge clk);
    mem_strobe = s; op_valid = v; opcode = op; operand = opr;
    #1;
    e_adv = 0; e_done = 0; e_busy = m_active;
    if (s && v && !m_active) begin
      lookup(op, opr, n, b);
      e_adv = 1; e_done = (n == 1);
    end else if (s && m_active) begin
      e_adv = (m_brem > 0); e_done = (m_rem == 1);
    end
    check("R5", "pc_adv", int'(pc_adv), e_adv);
    check("R6", "instr_done", int'(instr_done), e_done);
    check("R7", "busy", int'(busy), e_busy);
    @(posedge clk);
    if (s && v && !m_active) begin
      m_active = (n > 1); m_rem = n - 1; m_brem = b - 1;
    end else if (s && m_active) begin
      m_rem--; if (m_brem > 0) m_brem--; m_active = (m_rem > 0);
    end
  endtask

  // Issue one instruction; count strobes up to and including the done strobe
  task automatic run_instr(input string req, input logic [7:0] op, input logic [7:0] opr,
                           input int exp_n, input bit gaps, input bit noise);
    int cnt = 0;
    bit seen = 0;
    int advs = 0;
    int n, b;
    lookup(op, opr, n, b);
    for (int k = 0; k < 30 && !seen; k++) begin
      bit s;
      s = !(gaps && (k % 2 == 1));
      if (k == 0) s = 1;
      cycle(s, (k == 0) || noise, (k == 0) ? op : 8'h84, (k == 0) ? opr : 8'h00);
      if (s) cnt++;
      if (pc_adv) advs++;
      if (instr_done) seen = 1;
    end
    check(req, "strobes per instruction", cnt, exp_n);
    check("R5", "pc_adv strobes", advs, b);
    check("R1", "cycle count in 1..10", int'(cnt >= 1 && cnt <= 10), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "busy in reset", int'(busy), 0);
    check("R10", "pc_adv in reset", int'(pc_adv), 0);
    check("R10", "instr_done in reset", int'(instr_done), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) cycle(0, 0, 8'h00, 8'h00);

    run_instr("R2", 8'h13, 8'h00, 1, 0, 0);
    run_instr("R2", 8'hD4, 8'h00, 2, 0, 0);
    run_instr("R2", 8'h22, 8'h00, 3, 0, 0);
    run_instr("R2", 8'hA4, 8'h00, 9, 0, 0);
    run_instr("R2", 8'h84, 8'h00, 10, 0, 0);
    run_instr("R3", 8'h24, 8'hA8, 2, 0, 0);
    run_instr("R3", 8'h25, 8'h80, 2, 0, 0);
    run_instr("R3", 8'h80, 8'hD0, 3, 0, 0);
    run_instr("R4", 8'h25, 8'hA8, 3, 0, 0);
    run_instr("R4", 8'h25, 8'hD0, 3, 0, 0);
    run_instr("R4", 8'h25, 8'hF1, 3, 0, 0);
    run_instr("R11", 8'h00, 8'h00, 1, 0, 0);
    run_instr("R11", 8'hFF, 8'hA8, 1, 0, 0);
    run_instr("R8", 8'h22, 8'h00, 3, 0, 1);
    run_instr("R8", 8'h80, 8'h00, 3, 0, 1);
    run_instr("R9", 8'hA4, 8'h00, 9, 1, 0);
    run_instr("R9", 8'h25, 8'hB8, 3, 1, 1);

    // R9: idle cycles with valid but no strobe leave everything quiet
    repeat (3) cycle(0, 1, 8'h84, 8'h00);

    // R6: back-to-back acceptance on the strobe after done
    for (int i = 0; i < 40; i++) begin
      logic [7:0] ops [9] = '{8'h13, 8'hD4, 8'h22, 8'hA4, 8'h84, 8'h24, 8'h25, 8'h80, 8'h5A};
      cycle(1, 1, ops[i % 9], (i % 3 == 0) ? 8'hE8 : 8'h10);
    end

    // Random traffic compared every clock
    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom % 4) != 0, ($urandom % 2) == 0, 8'($urandom), 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule